// File: doc/BRIEF.md
# Interrupt Request Flag Bank

This block holds sixteen interrupt request flags for a small microcontroller, plus one enable bit per flag. A single-cycle event pulse from a peripheral sets that peripheral's flag, whether or not the flag is enabled. Software reads and writes both registers over a 16-bit register port. Two byte strobes let the port make 8-bit or 16-bit writes. Writing a 1 to a flag raises a request in the same way a hardware event does, and writing a 0 clears it.

The CPU interrupt line is asserted when any flag is set, its enable bit is set, and the master enable input is high. Among the flags that are both set and enabled, the lowest-numbered one is offered to the CPU, and its number appears on a source-ID output. When the CPU pulses its accept input while the line is high, the offered flag is cleared.

Ten bit positions have sources: bits 0 to 6 and bits 13 to 15. Bit 7 and bits 8 to 12 are not implemented.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, every flag and every enable bit is 0, `cpu_irq_o` is 0 and `src_id_o` is 0.
- R2: An `evt_i[k]` pulse on an implemented bit k sets flag k on the next clock edge, for any value of enable bit k and of `mie_i`.
- R3: `cpu_irq_o` is 1 exactly when `mie_i` is 1 and at least one bit is set in both the flag register and the enable register.
- R4: A write with `bus_sel`=0 loads the written flag bits from `bus_wdata`. Writing a 1 sets a flag, and an enabled flag then raises `cpu_irq_o`. Writing a 0 clears a flag.
- R5: `bus_be[0]` enables writes to bits 7:0 and `bus_be[1]` enables writes to bits 15:8. Bits in a lane whose strobe is low keep their value.
- R6: Bit 7 and bits 12:8 always read as 0 in both registers. Writes and events do not change them.
- R7: When an event and a software write of 0 reach the same flag in the same cycle, the flag ends up set.
- R8: If `cpu_ack_i` is 1 while `cpu_irq_o` is 1, the flag at `src_id_o` is cleared on the next edge. An event on that same flag in the same cycle keeps it set. If `cpu_ack_i` is 1 while `cpu_irq_o` is 0, no flag changes.
- R9: `src_id_o` gives the lowest bit index that is set in both the flag and enable registers. It is 0 when no such bit exists.
- R10: A write with `bus_sel`=1 goes to the enable register under the same byte-lane rules. `bus_rdata` returns the flag register when `bus_sel`=0 and the enable register when `bus_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Single-cycle event pulses, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 = flags, 1 = enables |
| bus_be | input | 2 | Byte-lane write strobes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| mie_i | input | 1 | Master interrupt enable |
| cpu_ack_i | input | 1 | CPU accepts the offered request |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| src_id_o | output | 4 | Index of the offered source |

## Verification
The flags are driven in three ways: by events, by software writes, and by CPU accepts. Each path is tried alone and then together with another path on the same bit in the same cycle. The coincident cases show whether the event path has priority over the two clearing paths.

Several pending patterns exercise source selection: a single high bit, adjacent high bits, all implemented bits, and patterns where the enable register hides the lowest flag. Together these distinguish a lowest-index picker from a highest-index picker and from a picker that ignores the enable bits. Writes of all ones under each strobe combination separate correct lane decoding from swapped lanes and from leaks into the unimplemented bits.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

  localparam int IRQF_W     = 16;
  localparam int IRQF_LANES = 2;
  localparam int IRQF_LANEW = IRQF_W / IRQF_LANES;
  localparam int IRQF_IDW   = $clog2(IRQF_W);

  // Bits 0..6 and 13..15 carry sources; the rest are not implemented.
  localparam logic [IRQF_W-1:0] IRQF_VALID = 16'hE07F;

  typedef enum logic {
    REG_FLAGS  = 1'b0,
    REG_ENABLE = 1'b1
  } irqf_sel_e;

  // Expand the byte strobes into a per-bit write mask.
  function automatic logic [IRQF_W-1:0] lane_mask(input logic [IRQF_LANES-1:0] be);
    logic [IRQF_W-1:0] m;
    m = '0;
    for (int l = 0; l < IRQF_LANES; l++) begin
      for (int b = 0; b < IRQF_LANEW; b++) begin
        m[l*IRQF_LANEW + b] = be[l];
      end
    end
    return m;
  endfunction

  // Take the new data where the mask is set and keep the old value elsewhere.
  function automatic logic [IRQF_W-1:0] merge_write(input logic [IRQF_W-1:0] old_v,
                                                    input logic [IRQF_W-1:0] new_v,
                                                    input logic [IRQF_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  // Keep only the lowest set bit.
  function automatic logic [IRQF_W-1:0] isolate_lowest(input logic [IRQF_W-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  // Turn a one-hot vector into its bit index.
  function automatic logic [IRQF_IDW-1:0] onehot_index(input logic [IRQF_W-1:0] oh);
    logic [IRQF_IDW-1:0] idx;
    idx = '0;
    for (int i = 0; i < IRQF_W; i++) begin
      if (oh[i]) idx = idx | IRQF_IDW'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank
  import irqf_pkg::*;
#(
  parameter logic [IRQF_W-1:0] VALID = IRQF_VALID
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQF_W-1:0] evt,
  input  logic              wr,
  input  logic [IRQF_W-1:0] wmask,
  input  logic [IRQF_W-1:0] wdata,
  input  logic [IRQF_W-1:0] ack_clr,
  output logic [IRQF_W-1:0] flag_q
);

  logic [IRQF_W-1:0] after_wr;
  logic [IRQF_W-1:0] after_ack;
  logic [IRQF_W-1:0] flag_d;

  // The software write is applied first, then the accept clear.
  // Events are ORed in last, so they take priority over both clears.
  always_comb begin
    after_wr  = wr ? merge_write(flag_q, wdata, wmask) : flag_q;
    after_ack = after_wr & ~ack_clr;
    flag_d    = (after_ack | evt) & VALID;
  end

  generate
    for (genvar i = 0; i < IRQF_W; i++) begin : g_bit
      if (VALID[i]) begin : g_impl
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) flag_q[i] <= 1'b0;
          else        flag_q[i] <= flag_d[i];
        end
      end else begin : g_tie
        assign flag_q[i] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/irqf_en_bank.sv
module irqf_en_bank
  import irqf_pkg::*;
#(
  parameter logic [IRQF_W-1:0] VALID = IRQF_VALID
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IRQF_W-1:0] wmask,
  input  logic [IRQF_W-1:0] wdata,
  output logic [IRQF_W-1:0] en_q
);

  logic [IRQF_W-1:0] en_d;

  always_comb begin
    en_d = wr ? merge_write(en_q, wdata, wmask) : en_q;
    en_d = en_d & VALID;
  end

  generate
    for (genvar i = 0; i < IRQF_W; i++) begin : g_bit
      if (VALID[i]) begin : g_impl
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) en_q[i] <= 1'b0;
          else        en_q[i] <= en_d[i];
        end
      end else begin : g_tie
        assign en_q[i] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/irqf_pick.sv
module irqf_pick
  import irqf_pkg::*;
(
  input  logic [IRQF_W-1:0]   pending,
  output logic                any,
  output logic [IRQF_W-1:0]   grant,
  output logic [IRQF_IDW-1:0] id
);

  always_comb begin
    any   = |pending;
    grant = isolate_lowest(pending);
    id    = onehot_index(grant);
  end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irqf_pkg::*;
#(
  parameter logic [IRQF_W-1:0] VALID_MASK = IRQF_VALID
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IRQF_W-1:0]   evt_i,
  input  logic                bus_wr,
  input  logic                bus_sel,
  input  logic [1:0]          bus_be,
  input  logic [IRQF_W-1:0]   bus_wdata,
  output logic [IRQF_W-1:0]   bus_rdata,
  input  logic                mie_i,
  input  logic                cpu_ack_i,
  output logic                cpu_irq_o,
  output logic [IRQF_IDW-1:0] src_id_o
);

  // Named internal events, brought out for the checker.
  logic [IRQF_W-1:0] lane_bits;
  logic              wr_flag;
  logic              wr_en;
  logic [IRQF_W-1:0] flag_q;
  logic [IRQF_W-1:0] en_q;
  logic [IRQF_W-1:0] pending;
  logic [IRQF_W-1:0] grant;
  logic              any_pending;
  logic              ack_take;
  logic [IRQF_W-1:0] ack_clr;

  assign lane_bits = lane_mask(bus_be);
  assign wr_flag   = bus_wr && (irqf_sel_e'(bus_sel) == REG_FLAGS);
  assign wr_en     = bus_wr && (irqf_sel_e'(bus_sel) == REG_ENABLE);

  irqf_flag_bank #(.VALID(VALID_MASK)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_i),
    .wr      (wr_flag),
    .wmask   (lane_bits),
    .wdata   (bus_wdata),
    .ack_clr (ack_clr),
    .flag_q  (flag_q)
  );

  irqf_en_bank #(.VALID(VALID_MASK)) u_enables (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_en),
    .wmask (lane_bits),
    .wdata (bus_wdata),
    .en_q  (en_q)
  );

  assign pending = flag_q & en_q;

  irqf_pick u_pick (
    .pending (pending),
    .any     (any_pending),
    .grant   (grant),
    .id      (src_id_o)
  );

  // The per-source enable is applied first, then the master enable.
  assign cpu_irq_o = any_pending && mie_i;
  assign ack_take  = cpu_ack_i && cpu_irq_o;
  assign ack_clr   = ack_take ? grant : '0;

  assign bus_rdata = (irqf_sel_e'(bus_sel) == REG_ENABLE) ? en_q : flag_q;

endmodule

// File: rtl/irqf_chk.sv
module irqf_chk
  import irqf_pkg::*;
#(
  parameter logic [IRQF_W-1:0] VALID = IRQF_VALID
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mie_i,
  input logic                cpu_ack_i,
  input logic [IRQF_W-1:0]   evt_i,
  input logic                cpu_irq_o,
  input logic [IRQF_IDW-1:0] src_id_o,
  input logic [IRQF_W-1:0]   flag_q,
  input logic [IRQF_W-1:0]   en_q,
  input logic [IRQF_W-1:0]   pending,
  input logic                ack_take,
  input logic                wr_flag
);

  AST_IRQ_NEEDS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o |-> mie_i); // R3
  AST_IRQ_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mie_i && ((flag_q & en_q) != '0)) |-> cpu_irq_o); // R3
  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & VALID) != '0) |=> ((flag_q & $past(evt_i & VALID)) == $past(evt_i & VALID))); // R2
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~VALID) == '0) && ((en_q & ~VALID) == '0)); // R6
  AST_ID_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o |-> pending[src_id_o]); // R9
  AST_ID_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o |-> ((pending & ((16'h1 << src_id_o) - 16'h1)) == '0)); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !evt_i[src_id_o] && !wr_flag) |=> !flag_q[$past(src_id_o)]); // R8
  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack_i && !cpu_irq_o && !wr_flag) |=> (($past(flag_q) & ~flag_q) == '0)); // R8
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flag_q & ~$past(flag_q) & ~$past(evt_i)) == '0)); // R2

endmodule

bind irq_flag_bank irqf_chk #(.VALID(VALID_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mie_i     (mie_i),
  .cpu_ack_i (cpu_ack_i),
  .evt_i     (evt_i),
  .cpu_irq_o (cpu_irq_o),
  .src_id_o  (src_id_o),
  .flag_q    (flag_q),
  .en_q      (en_q),
  .pending   (pending),
  .ack_take  (ack_take),
  .wr_flag   (wr_flag)
);

// File: tb/tb_irq_flag_bank.sv
`timescale 1ns/1ps
module tb_irq_flag_bank;

  localparam logic [15:0] IMPL = 16'hE07F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_i = '0;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        mie_i = 1'b0;
  logic        cpu_ack_i = 1'b0;
  logic        cpu_irq_o;
  logic [3:0]  src_id_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  irq_flag_bank dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mie_i(mie_i),
    .cpu_ack_i(cpu_ack_i), .cpu_irq_o(cpu_irq_o), .src_id_o(src_id_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent model of the source picker: the lowest index set in both registers.
  function automatic logic [3:0] lowest_of(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  // Inputs are driven on negedges, so each write completes before the next negedge.
  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic rd(input logic sel, output logic [15:0] d);
    bus_sel = sel;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic clear_all();
    wr(1'b0, 2'b11, 16'h0000);
    wr(1'b1, 2'b11, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(1'b0, v); check("R1 flags", v, 16'h0000);
    rd(1'b1, v); check("R1 enables", v, 16'h0000);
    check("R1 irq", {15'd0, cpu_irq_o}, 16'h0);
    check("R1 id", {12'd0, src_id_o}, 16'h0);
  endtask

  task automatic t_event_latch();
    logic [15:0] v;
    mie_i = 1'b0;
    pulse(16'h8024);
    rd(1'b0, v); check("R2 latch while disabled", v, 16'h8024);
    check("R3 no irq without enable", {15'd0, cpu_irq_o}, 16'h0);
    clear_all();
  endtask

  task automatic t_gating();
    logic [15:0] v;
    pulse(16'h0010);
    wr(1'b1, 2'b11, 16'h0010);
    mie_i = 1'b0; #1;
    check("R3 mie low", {15'd0, cpu_irq_o}, 16'h0);
    mie_i = 1'b1; #1;
    check("R3 mie high", {15'd0, cpu_irq_o}, 16'h1);
    wr(1'b1, 2'b11, 16'h0001);
    check("R3 enable mismatch", {15'd0, cpu_irq_o}, 16'h0);
    rd(1'b1, v); check("R10 enable readback", v, 16'h0001);
    clear_all();
  endtask

  task automatic t_sw_write();
    logic [15:0] v;
    wr(1'b1, 2'b11, 16'h2000);
    wr(1'b0, 2'b11, 16'h2000);
    check("R4 sw set raises irq", {15'd0, cpu_irq_o}, 16'h1);
    check("R4 sw set id", {12'd0, src_id_o}, 16'd13);
    wr(1'b0, 2'b11, 16'h0000);
    rd(1'b0, v); check("R4 sw clear", v, 16'h0000);
    check("R4 irq drops", {15'd0, cpu_irq_o}, 16'h0);
    clear_all();
  endtask

  task automatic t_lanes();
    logic [15:0] v;
    wr(1'b0, 2'b01, 16'hFFFF);
    rd(1'b0, v); check("R5 low lane only", v, 16'h007F);
    wr(1'b0, 2'b10, 16'h0000);
    rd(1'b0, v); check("R5 high lane zero keeps low", v, 16'h007F);
    wr(1'b0, 2'b10, 16'hFFFF);
    rd(1'b0, v); check("R6 unused flags zero", v, 16'hE07F);
    wr(1'b0, 2'b00, 16'h0000);
    rd(1'b0, v); check("R5 no strobe no change", v, 16'hE07F);
    wr(1'b1, 2'b10, 16'hFFFF);
    rd(1'b1, v); check("R10 enable high lane", v, 16'hE000);
    wr(1'b1, 2'b01, 16'hFFFF);
    rd(1'b1, v); check("R6 unused enables zero", v, 16'hE07F);
    clear_all();
    pulse(16'h1F80);
    rd(1'b0, v); check("R6 event on unused bit", v, 16'h0000);
  endtask

  task automatic t_evt_vs_clear();
    logic [15:0] v;
    wr(1'b0, 2'b01, 16'h0003);
    @(negedge clk);
    evt_i = 16'h0001;
    bus_wr = 1'b1; bus_sel = 1'b0; bus_be = 2'b01; bus_wdata = 16'h0000;
    @(negedge clk);
    evt_i = '0; bus_wr = 1'b0; bus_be = 2'b00;
    rd(1'b0, v); check("R7 event beats sw clear", v, 16'h0001);
    clear_all();
  endtask

  task automatic t_priority();
    logic [15:0] pats [5] = '{16'h8000, 16'h6000, 16'hE07F, 16'h0003, 16'h4040};
    logic [15:0] ens  [5] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0002, 16'hC000};
    mie_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wr(1'b0, 2'b11, pats[k]);
      wr(1'b1, 2'b11, ens[k]);
      check("R9 lowest pending id", {12'd0, src_id_o}, {12'd0, lowest_of(pats[k] & ens[k] & IMPL)});
      clear_all();
    end
    check("R9 idle id", {12'd0, src_id_o}, 16'h0);
  endtask

  task automatic t_ack();
    logic [15:0] v;
    mie_i = 1'b1;
    wr(1'b1, 2'b11, 16'h0024);
    pulse(16'h0024);
    check("R9 id before ack", {12'd0, src_id_o}, 16'd2);
    @(negedge clk); cpu_ack_i = 1'b1;
    @(negedge clk); cpu_ack_i = 1'b0;
    rd(1'b0, v); check("R8 ack clears offered flag", v, 16'h0020);
    check("R8 next id", {12'd0, src_id_o}, 16'd5);
    @(negedge clk); cpu_ack_i = 1'b1; evt_i = 16'h0020;
    @(negedge clk); cpu_ack_i = 1'b0; evt_i = '0;
    rd(1'b0, v); check("R8 event with ack keeps flag", v, 16'h0020);
    mie_i = 1'b0;
    @(negedge clk); cpu_ack_i = 1'b1;
    @(negedge clk); cpu_ack_i = 1'b0;
    rd(1'b0, v); check("R8 ack ignored without irq", v, 16'h0020);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_event_latch();
    t_gating();
    t_sw_write();
    t_lanes();
    t_evt_vs_clear();
    t_priority();
    t_ack();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule